// File: doc/BRIEF.md
# Redundant Dual-Beam Permit Matrix

This block merges the permit lines of a set of user systems into one permit per beam for a two-beam machine. Every user drives two redundant channels, A and B. The two channels are evaluated by two copies of the same logic that share no gates, and each copy produces its own beam-1 and beam-2 permit. A user slot belongs to one of three fixed groups, set by its index: beam-1 only, both beams, or beam-2 only. A both-beam user therefore takes away the permit of both beams, while the other users reach only their own beam.

A pair of redundant safe-beam lines is resolved conservatively. The beam counts as safe only when both lines say so, and any disagreement is taken as not safe. While the resolved flag is true, a beam-only user may be masked, so that its permit is ignored. Masks on both-beam users never take effect.

The block also keeps a first-fault record. This is the lowest index among the users whose effective permit was down in the first cycle of a fault, together with the channels that were down. The record is held until it is cleared. For each beam, a discrepancy monitor flags an A/B disagreement that lasts too long.

Top module: `dual_beam_permit_matrix`

## Requirements
- R1: While reset is asserted, all permit outputs, `safe_beam`, `first_valid`, `first_idx`, `first_chan` and both discrepancy flags are 0.
- R2: Slots 0 to N_B1+N_BOTH-1 feed beam 1. One clock after the inputs are presented, `b1_permit_x` is the AND of the effective permits of those slots on channel x. When any both-beam slot is down, both beams lose the permit on that channel.
- R3: Slots N_B1 to N_B1+N_BOTH+N_B2-1 feed beam 2, with the same one-clock latency. `b2_permit_x` is the AND of their effective permits on channel x.
- R4: Channel A outputs depend only on `user_a`, and channel B outputs depend only on `user_b`.
- R5: One clock after the inputs are presented, `safe_beam` is 1 only if `safe_a` and `safe_b` are both 1. A disagreement between the two lines yields 0.
- R6: The effective permit of a slot is its input OR its mask bit. The mask bit counts only in a cycle where `safe_a` and `safe_b` are both 1.
- R7: Mask bits on both-beam slots (indices N_B1 to N_B1+N_BOTH-1) have no effect, whether for the permits or for the first-fault record.
- R8: With no fault held, the first cycle in which any slot has an effective permit of 0 latches `first_valid`=1 and `first_idx`=the lowest such index. In that same cycle `first_chan` is latched as bit 0 = channel A down and bit 1 = channel B down, for that slot. The outputs show this one clock later.
- R9: A held record stays unchanged until `fault_clr`. A clock edge with `fault_clr` high sets `first_valid` to 0 and takes priority over capture. Capture resumes at the next edge.
- R10: `disc_bN` is 1 exactly while the registered A and B permits of beam N have differed on at least DISC_LIMIT consecutive cycles, counting the current one. It returns to 0 on the first cycle in which they agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_a | input | N_USERS | Channel A permit per user slot |
| user_b | input | N_USERS | Channel B permit per user slot |
| mask_req | input | N_USERS | Mask request per user slot |
| safe_a | input | 1 | Safe-beam line, copy 1 |
| safe_b | input | 1 | Safe-beam line, copy 2 |
| fault_clr | input | 1 | Clears the first-fault record |
| b1_permit_a | output | 1 | Beam-1 permit, channel A |
| b1_permit_b | output | 1 | Beam-1 permit, channel B |
| b2_permit_a | output | 1 | Beam-2 permit, channel A |
| b2_permit_b | output | 1 | Beam-2 permit, channel B |
| safe_beam | output | 1 | Resolved safe-beam flag |
| first_valid | output | 1 | First-fault record is held |
| first_idx | output | IDXW | Slot index of the first fault |
| first_chan | output | 2 | Channels down at capture (bit 0 A, bit 1 B) |
| disc_b1 | output | 1 | Persistent A/B mismatch on beam 1 |
| disc_b2 | output | 1 | Persistent A/B mismatch on beam 2 |

## Verification
The bench builds the block with two slots in each group (six users) and DISC_LIMIT of 4. At that size, all 64 channel patterns can be swept against four mask patterns and all four safe-line combinations, and each sweep checks every beam permit against an arithmetic model. A second sweep varies only channel B, which exposes any leak between the two channels. The short discrepancy window allows the exact cycle on which each flag rises to be checked. Directed sequences then cover the lowest-index priority of the first-fault record, its hold and clear behaviour, and the way masking changes it.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        CAT_B1   = 2'd0,
        CAT_BOTH = 2'd1,
        CAT_B2   = 2'd2
    } slot_cat_e;

    // Group of a slot, fixed by its index.
    function automatic slot_cat_e slot_cat(input int idx, input int nb1, input int nboth);
        if (idx < nb1)              return CAT_B1;
        else if (idx < nb1 + nboth) return CAT_BOTH;
        else                        return CAT_B2;
    endfunction

endpackage

// File: rtl/pm_channel_tree.sv
module pm_channel_tree #(
    parameter int N_B1   = 6,
    parameter int N_BOTH = 8,
    parameter int N_B2   = 6,
    localparam int N     = N_B1 + N_BOTH + N_B2
) (
    input  logic [N-1:0] perm,
    input  logic [N-1:0] mask_eff,
    output logic [N-1:0] eff,
    output logic         beam1,
    output logic         beam2
);
    logic [N-1:0] rel1;
    logic [N-1:0] rel2;

    for (genvar i = 0; i < N; i++) begin : g_rel
        localparam pm_pkg::slot_cat_e C = pm_pkg::slot_cat(i, N_B1, N_BOTH);
        assign rel1[i] = (C != pm_pkg::CAT_B2);
        assign rel2[i] = (C != pm_pkg::CAT_B1);
    end

    always_comb begin
        eff   = perm | mask_eff;
        beam1 = &(eff | ~rel1);
        beam2 = &(eff | ~rel2);
    end
endmodule

// File: rtl/pm_first_fault.sv
module pm_first_fault #(
    parameter int N    = 20,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    down_a,
    input  logic [N-1:0]    down_b,
    input  logic            clr,
    output logic            valid,
    output logic [IDXW-1:0] idx,
    output logic [1:0]      chan
);
    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
        logic [1:0]      chan;
    } ff_state_t;

    ff_state_t st_d, st_q;
    logic            hit;
    logic [IDXW-1:0] pick;

    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (down_a[i] || down_b[i]) begin
                hit  = 1'b1;
                pick = IDXW'(i);
            end
        end

        st_d = st_q;
        if (clr) begin
            st_d.valid = 1'b0;
        end else if (!st_q.valid && hit) begin
            st_d.valid = 1'b1;
            st_d.idx   = pick;
            st_d.chan  = {down_b[pick], down_a[pick]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign idx   = st_q.idx;
    assign chan  = st_q.chan;
endmodule

// File: rtl/pm_disc_monitor.sv
module pm_disc_monitor #(
    parameter int DISC_LIMIT = 16,
    localparam int CW = $clog2(DISC_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic perm_a_d,
    input  logic perm_b_d,
    output logic flag
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } dm_state_t;

    dm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (perm_a_d != perm_b_d) begin
            if (st_q.cnt != CW'(DISC_LIMIT)) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = (st_q.cnt == CW'(DISC_LIMIT));
endmodule

// File: rtl/dual_beam_permit_matrix.sv
module dual_beam_permit_matrix #(
    parameter int N_B1       = 6,
    parameter int N_BOTH     = 8,
    parameter int N_B2       = 6,
    parameter int DISC_LIMIT = 16,
    localparam int N_USERS   = N_B1 + N_BOTH + N_B2,
    localparam int IDXW      = (N_USERS > 1) ? $clog2(N_USERS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_USERS-1:0] user_a,
    input  logic [N_USERS-1:0] user_b,
    input  logic [N_USERS-1:0] mask_req,
    input  logic               safe_a,
    input  logic               safe_b,
    input  logic               fault_clr,
    output logic               b1_permit_a,
    output logic               b1_permit_b,
    output logic               b2_permit_a,
    output logic               b2_permit_b,
    output logic               safe_beam,
    output logic               first_valid,
    output logic [IDXW-1:0]    first_idx,
    output logic [1:0]         first_chan,
    output logic               disc_b1,
    output logic               disc_b2
);
    typedef struct packed {
        logic b1a;
        logic b1b;
        logic b2a;
        logic b2b;
        logic safe;
    } top_state_t;

    top_state_t st_d, st_q;

    logic               safe_now;
    logic [N_USERS-1:0] maskable;
    logic [N_USERS-1:0] mask_eff;
    logic [N_USERS-1:0] perm_ch  [2];
    logic [N_USERS-1:0] eff_ch   [2];
    logic [1:0]         beam1_ch;
    logic [1:0]         beam2_ch;

    // Only beam-only slots accept a mask.
    for (genvar i = 0; i < N_USERS; i++) begin : g_mask
        localparam pm_pkg::slot_cat_e C = pm_pkg::slot_cat(i, N_B1, N_BOTH);
        assign maskable[i] = (C != pm_pkg::CAT_BOTH);
    end

    // Both safe lines must agree on "safe".
    assign safe_now = safe_a & safe_b;
    assign mask_eff = mask_req & maskable & {N_USERS{safe_now}};

    assign perm_ch[0] = user_a;
    assign perm_ch[1] = user_b;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        pm_channel_tree #(
            .N_B1   (N_B1),
            .N_BOTH (N_BOTH),
            .N_B2   (N_B2)
        ) u_tree (
            .perm     (perm_ch[c]),
            .mask_eff (mask_eff),
            .eff      (eff_ch[c]),
            .beam1    (beam1_ch[c]),
            .beam2    (beam2_ch[c])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.b1a  = beam1_ch[0];
        st_d.b1b  = beam1_ch[1];
        st_d.b2a  = beam2_ch[0];
        st_d.b2b  = beam2_ch[1];
        st_d.safe = safe_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign b1_permit_a = st_q.b1a;
    assign b1_permit_b = st_q.b1b;
    assign b2_permit_a = st_q.b2a;
    assign b2_permit_b = st_q.b2b;
    assign safe_beam   = st_q.safe;

    pm_first_fault #(
        .N (N_USERS)
    ) u_first (
        .clk    (clk),
        .rst_n  (rst_n),
        .down_a (~eff_ch[0]),
        .down_b (~eff_ch[1]),
        .clr    (fault_clr),
        .valid  (first_valid),
        .idx    (first_idx),
        .chan   (first_chan)
    );

    pm_disc_monitor #(
        .DISC_LIMIT (DISC_LIMIT)
    ) u_disc_b1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .perm_a_d (st_d.b1a),
        .perm_b_d (st_d.b1b),
        .flag     (disc_b1)
    );

    pm_disc_monitor #(
        .DISC_LIMIT (DISC_LIMIT)
    ) u_disc_b2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .perm_a_d (st_d.b2a),
        .perm_b_d (st_d.b2b),
        .flag     (disc_b2)
    );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int N_B1       = 6,
    parameter int N_BOTH     = 8,
    parameter int N_B2       = 6,
    parameter int DISC_LIMIT = 16,
    localparam int N_USERS   = N_B1 + N_BOTH + N_B2,
    localparam int IDXW      = (N_USERS > 1) ? $clog2(N_USERS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_USERS-1:0] user_a,
    input logic [N_USERS-1:0] user_b,
    input logic [N_USERS-1:0] mask_req,
    input logic               safe_a,
    input logic               safe_b,
    input logic               fault_clr,
    input logic               b1_permit_a,
    input logic               b1_permit_b,
    input logic               b2_permit_a,
    input logic               b2_permit_b,
    input logic               safe_beam,
    input logic               first_valid,
    input logic [IDXW-1:0]    first_idx,
    input logic [1:0]         first_chan,
    input logic               disc_b1,
    input logic               disc_b2
);
    logic [N_USERS-1:0] both_vec;
    logic [N_USERS-1:0] b1_vec;

    for (genvar i = 0; i < N_USERS; i++) begin : g_vec
        localparam pm_pkg::slot_cat_e C = pm_pkg::slot_cat(i, N_B1, N_BOTH);
        assign both_vec[i] = (C == pm_pkg::CAT_BOTH);
        assign b1_vec[i]   = (C != pm_pkg::CAT_B2);
    end

    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (!b1_permit_a && !b1_permit_b && !b2_permit_a && !b2_permit_b
                                && !safe_beam && !first_valid && !disc_b1 && !disc_b2);
        end
    end

    p_both_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((user_a & both_vec) != both_vec) |=> (!b1_permit_a && !b2_permit_a));

    p_chan_b_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((user_b & both_vec) != both_vec) |=> (!b1_permit_b && !b2_permit_b));

    p_safe_needs_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!safe_a || !safe_b) |=> !safe_beam);

    p_mask_needs_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(safe_a && safe_b) && ((user_a & b1_vec) != b1_vec)) |=> !b1_permit_a);

    p_first_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> (first_chan != 2'b00));

    p_first_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (first_valid && !fault_clr) |=> (first_valid && $stable(first_idx) && $stable(first_chan)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> !first_valid);

    p_disc_mismatch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_b1 |-> (b1_permit_a != b1_permit_b)) and (disc_b2 |-> (b2_permit_a != b2_permit_b)));
endmodule

bind dual_beam_permit_matrix pm_checker #(
    .N_B1       (N_B1),
    .N_BOTH     (N_BOTH),
    .N_B2       (N_B2),
    .DISC_LIMIT (DISC_LIMIT)
) u_pm_checker (.*);

// File: tb/tb_dual_beam_permit_matrix.sv
module tb_dual_beam_permit_matrix;
    localparam int CLK_PERIOD = 10;
    localparam int NB1 = 2;
    localparam int NBOTH = 2;
    localparam int NB2 = 2;
    localparam int LIM = 4;
    localparam int N = NB1 + NBOTH + NB2;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] user_a = '1;
    logic [N-1:0] user_b = '1;
    logic [N-1:0] mask_req = '0;
    logic safe_a = 1'b0;
    logic safe_b = 1'b0;
    logic fault_clr = 1'b0;
    logic b1_permit_a, b1_permit_b, b2_permit_a, b2_permit_b, safe_beam;
    logic first_valid;
    logic [IW-1:0] first_idx;
    logic [1:0] first_chan;
    logic disc_b1, disc_b2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_beam_permit_matrix #(
        .N_B1(NB1), .N_BOTH(NBOTH), .N_B2(NB2), .DISC_LIMIT(LIM)
    ) dut (
        .clk(clk), .rst_n(rst_n), .user_a(user_a), .user_b(user_b),
        .mask_req(mask_req), .safe_a(safe_a), .safe_b(safe_b), .fault_clr(fault_clr),
        .b1_permit_a(b1_permit_a), .b1_permit_b(b1_permit_b),
        .b2_permit_a(b2_permit_a), .b2_permit_b(b2_permit_b),
        .safe_beam(safe_beam), .first_valid(first_valid), .first_idx(first_idx),
        .first_chan(first_chan), .disc_b1(disc_b1), .disc_b2(disc_b2)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Slots 0,1 beam-1 only; 2,3 both; 4,5 beam-2 only.
    function automatic logic [N-1:0] eff(input logic [N-1:0] p, input logic [N-1:0] m, input bit s);
        logic [N-1:0] mm;
        mm = s ? (m & 6'b110011) : '0;
        return p | mm;
    endfunction

    function automatic bit exp_b1(input logic [N-1:0] e);
        return &e[3:0];
    endfunction

    function automatic bit exp_b2(input logic [N-1:0] e);
        return &e[5:2];
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] masks [4];
        masks[0] = 6'h00; masks[1] = 6'h3F; masks[2] = 6'h15; masks[3] = 6'h2A;

        // R1: reset state with inputs all permitting
        safe_a = 1'b1; safe_b = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 b1_permit_a", int'(b1_permit_a), 0);
        chk("R1 b2_permit_b", int'(b2_permit_b), 0);
        chk("R1 safe_beam", int'(safe_beam), 0);
        chk("R1 first_valid", int'(first_valid), 0);
        chk("R1 disc", int'({disc_b1, disc_b2}), 0);
        rst_n = 1'b1;
        fault_clr = 1'b1;
        step();

        // Sweep 1: identical channels, all patterns, masks and safe combinations (R2 R3 R5 R6 R7)
        for (int p = 0; p < 64; p++) begin
            for (int mi = 0; mi < 4; mi++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [N-1:0] e;
                    user_a = N'(p); user_b = N'(p); mask_req = masks[mi];
                    safe_a = s[0]; safe_b = s[1];
                    e = eff(N'(p), masks[mi], s == 3);
                    step();
                    chk("R2 b1_permit_a", int'(b1_permit_a), int'(exp_b1(e)));
                    chk("R2 b1_permit_b", int'(b1_permit_b), int'(exp_b1(e)));
                    chk("R3 b2_permit_a", int'(b2_permit_a), int'(exp_b2(e)));
                    chk("R3 b2_permit_b", int'(b2_permit_b), int'(exp_b2(e)));
                    chk("R5 safe_beam", int'(safe_beam), int'(s == 3));
                end
            end
        end

        // Sweep 2: channel A held high, channel B swept (R4)
        mask_req = '0; safe_a = 1'b0; safe_b = 1'b0;
        for (int p = 0; p < 64; p++) begin
            user_a = '1; user_b = N'(p);
            step();
            chk("R4 b1_permit_a", int'(b1_permit_a), 1);
            chk("R4 b2_permit_a", int'(b2_permit_a), 1);
            chk("R4 b1_permit_b", int'(b1_permit_b), int'(exp_b1(N'(p))));
            chk("R4 b2_permit_b", int'(b2_permit_b), int'(exp_b2(N'(p))));
        end

        // R6 directed: masked beam-1 slot only counts with both safe lines high
        user_a = 6'b111110; user_b = 6'b111110; mask_req = 6'b000001;
        safe_a = 1'b1; safe_b = 1'b1;
        step();
        chk("R6 masked safe b1", int'(b1_permit_a), 1);
        safe_b = 1'b0;
        step();
        chk("R6 masked unsafe b1", int'(b1_permit_a), 0);
        chk("R5 disagree", int'(safe_beam), 0);

        // R7 directed: mask on both-beam slot ignored
        user_a = 6'b111011; user_b = 6'b111011; mask_req = 6'b000100;
        safe_a = 1'b1; safe_b = 1'b1;
        step();
        chk("R7 both mask b1", int'(b1_permit_a), 0);
        chk("R7 both mask b2", int'(b2_permit_b), 0);

        // First fault (R8 R9)
        user_a = '1; user_b = '1; mask_req = '0; safe_a = 1'b0; safe_b = 1'b0;
        fault_clr = 1'b1;
        step();
        fault_clr = 1'b0;
        step();
        chk("R8 idle valid", int'(first_valid), 0);
        user_a = 6'b110111; user_b = 6'b111101;
        step();
        chk("R8 valid", int'(first_valid), 1);
        chk("R8 lowest idx", int'(first_idx), 1);
        chk("R8 chan B", int'(first_chan), 2);
        user_a = 6'b110110;
        step();
        chk("R9 hold idx", int'(first_idx), 1);
        chk("R9 hold chan", int'(first_chan), 2);
        fault_clr = 1'b1;
        step();
        chk("R9 cleared", int'(first_valid), 0);
        fault_clr = 1'b0;
        step();
        chk("R9 recapture valid", int'(first_valid), 1);
        chk("R9 recapture idx", int'(first_idx), 0);
        chk("R9 recapture chan", int'(first_chan), 1);

        // Masked slot does not record; masked both-beam slot does (R8 R7)
        user_a = '1; user_b = '1; fault_clr = 1'b1;
        step();
        fault_clr = 1'b0; safe_a = 1'b1; safe_b = 1'b1;
        mask_req = 6'b000001; user_a = 6'b111110;
        step();
        chk("R8 masked no capture", int'(first_valid), 0);
        mask_req = 6'b000101; user_b = 6'b111011;
        step();
        chk("R7 both-beam capture valid", int'(first_valid), 1);
        chk("R7 both-beam capture idx", int'(first_idx), 2);
        chk("R7 both-beam capture chan", int'(first_chan), 2);

        // Discrepancy (R10)
        user_a = '1; user_b = '1; mask_req = '0; safe_a = 1'b0; safe_b = 1'b0;
        repeat (3) step();
        chk("R10 idle", int'(disc_b1), 0);
        user_b = 6'b111110;
        for (int k = 1; k <= LIM + 1; k++) begin
            step();
            chk("R10 disc_b1 window", int'(disc_b1), int'(k >= LIM));
            chk("R10 disc_b2 quiet", int'(disc_b2), 0);
        end
        user_b = '1;
        step();
        chk("R10 disc_b1 drop", int'(disc_b1), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule